// File: doc/BRIEF.md
# IrDA Frame CRC-16 Engine

This block is a small CRC accelerator that software drives through a 16-bit register port. Each write to the data-input register hands the engine one item. The engine folds the low byte of that item into a running 16-bit CRC in a single clock cycle and adds one to a 12-bit count of absorbed items. Software reads the count from the control register. It reads the finished frame check value from the output register, or the raw internal state from the calculation register.

A write to the control register with the clear bit set starts a new frame. Before it trusts the engine, software can clear it, feed the four-byte check vector 0xCC, 0xF5, 0xF1, 0xA7, and then expect a count of 4 and an output of 0x51DF. The CRC is the reflected CCITT code used on IrDA SIR links. The state starts at all ones and the result is the bitwise complement of the state.

Top module: `irda_crc16_engine`

## Requirements
- R1: After rst_n is released, the item count reads 0, the calculation register reads 0xFFFF and the output register reads 0x0000.
- R2: A write to the control register (byte offset 0x80) with bit 15 set clears the count to 0 and loads the state with 0xFFFF. A control write with bit 15 clear changes nothing.
- R3: Each write to the input register (offset 0x86) absorbs exactly one item. The new count and CRC are readable in the cycle after the write's clock edge. Writes on consecutive cycles are each absorbed.
- R4: The CRC uses polynomial x^16+x^12+x^5+1 in reflected form (0x8408). It processes bits 7:0 of each item least significant bit first, from an initial state of 0xFFFF. The output register (offset 0x8E) reads the bitwise complement of the state.
- R5: Bits 15:8 of an input write do not affect the CRC.
- R6: After a clear, the items 0xCC, 0xF5, 0xF1, 0xA7 give a count of 4 and an output of 0x51DF.
- R7: The count stops at 0xFFF and does not wrap. Later items still update the CRC.
- R8: The calculation register (offset 0x8A) reads the raw state without conditioning. After the R6 vector it reads 0xAE20.
- R9: Writes to the calculation register, to the output register or to an unmapped offset change neither the count nor the CRC. Reads of the input register or of an unmapped offset return 0. Bit 15 and bits 14:12 of the control register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | 8 | Byte offset of the register accessed |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the register at addr, combinational |

## Verification
The checker assumes that one address and at most one write are present in any cycle. It also assumes that wr_en, addr and wr_data are stable around the rising edge. The bench holds to this by changing inputs only on the falling edge and by driving a single shared address. It never relies on a read and a write of different registers in the same cycle, because reads are taken only while wr_en is low.

// File: rtl/irda_crc_pkg.sv
package irda_crc_pkg;
    localparam int unsigned CRC_BITS  = 16;
    localparam int unsigned CNT_BITS  = 12;
    localparam int unsigned REG_BITS  = 16;
    localparam int unsigned ITEM_BITS = 8;
    localparam logic [CRC_BITS-1:0] CCITT_REFLECTED = 16'h8408;
    localparam logic [CRC_BITS-1:0] CRC_SEED        = 16'hFFFF;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_DIN,
        SEL_CALC,
        SEL_OUT
    } reg_sel_e;
endpackage

// File: rtl/crc_addr_decode.sv
module crc_addr_decode
    import irda_crc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h80,
    parameter logic [ADDR_W-1:0] DIN_OFS  = 8'h86,
    parameter logic [ADDR_W-1:0] CALC_OFS = 8'h8A,
    parameter logic [ADDR_W-1:0] OUT_OFS  = 8'h8E
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        if (addr == CTRL_OFS)      sel = SEL_CTRL;
        else if (addr == DIN_OFS)  sel = SEL_DIN;
        else if (addr == CALC_OFS) sel = SEL_CALC;
        else if (addr == OUT_OFS)  sel = SEL_OUT;
        else                       sel = SEL_NONE;
    end
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
    parameter int unsigned CRC_W  = 16,
    parameter int unsigned BYTE_W = 8,
    parameter logic [CRC_W-1:0] POLY = 16'h8408
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] stage [BYTE_W+1];

    assign stage[0] = crc_in;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        logic fb;
        assign fb = stage[b][0] ^ byte_in[b];
        assign stage[b+1] = (stage[b] >> 1) ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/crc_sat_count.sv
module crc_sat_count #(
    parameter int unsigned CNT_W = 12
) (
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] cnt_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_comb begin
        if (cnt_in == CNT_MAX) cnt_out = cnt_in;
        else                   cnt_out = cnt_in + 1'b1;
    end
endmodule

// File: rtl/irda_crc16_engine.sv
module irda_crc16_engine
    import irda_crc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = REG_BITS,
    parameter int unsigned CRC_W   = CRC_BITS,
    parameter int unsigned CNT_W   = CNT_BITS,
    parameter int unsigned BYTE_W  = ITEM_BITS,
    parameter int unsigned CLR_BIT = 15,
    parameter logic [CRC_W-1:0]  POLY     = CCITT_REFLECTED,
    parameter logic [CRC_W-1:0]  INIT     = CRC_SEED,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h80,
    parameter logic [ADDR_W-1:0] DIN_OFS  = 8'h86,
    parameter logic [ADDR_W-1:0] CALC_OFS = 8'h8A,
    parameter logic [ADDR_W-1:0] OUT_OFS  = 8'h8E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned CNT_PAD = DATA_W - CNT_W;
    localparam int unsigned CRC_PAD = DATA_W - CRC_W;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CNT_W-1:0] cnt;
    } engine_state_t;

    engine_state_t st_d, st_q;
    reg_sel_e      sel;
    logic [CRC_W-1:0] crc_step;
    logic [CNT_W-1:0] cnt_inc;
    logic [CRC_W-1:0] crc_q;
    logic [CNT_W-1:0] cnt_q;

    assign crc_q = st_q.crc;
    assign cnt_q = st_q.cnt;

    crc_addr_decode #(
        .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .DIN_OFS(DIN_OFS),
        .CALC_OFS(CALC_OFS), .OUT_OFS(OUT_OFS)
    ) u_decode (
        .addr(addr),
        .sel (sel)
    );

    crc_byte_step #(
        .CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY)
    ) u_step (
        .crc_in (st_q.crc),
        .byte_in(wr_data[BYTE_W-1:0]),
        .crc_out(crc_step)
    );

    crc_sat_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .cnt_in (st_q.cnt),
        .cnt_out(cnt_inc)
    );

    // next-state: clear on control write, absorb on input write
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                SEL_CTRL: begin
                    if (wr_data[CLR_BIT]) begin
                        st_d.crc = INIT;
                        st_d.cnt = '0;
                    end
                end
                SEL_DIN: begin
                    st_d.crc = crc_step;
                    st_d.cnt = cnt_inc;
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.crc <= INIT;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        case (sel)
            SEL_CTRL: rd_data = {{CNT_PAD{1'b0}}, st_q.cnt};
            SEL_CALC: rd_data = {{CRC_PAD{1'b0}}, st_q.crc};
            SEL_OUT:  rd_data = {{CRC_PAD{1'b0}}, ~st_q.crc};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irda_crc16_checker.sv
module irda_crc16_checker #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned CRC_W   = 16,
    parameter int unsigned CNT_W   = 12,
    parameter int unsigned CLR_BIT = 15,
    parameter logic [CRC_W-1:0]  INIT     = 16'hFFFF,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h80,
    parameter logic [ADDR_W-1:0] DIN_OFS  = 8'h86,
    parameter logic [ADDR_W-1:0] CALC_OFS = 8'h8A,
    parameter logic [ADDR_W-1:0] OUT_OFS  = 8'h8E
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [CRC_W-1:0]  crc_q,
    input logic [CNT_W-1:0]  cnt_q
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_OFS && wr_data[CLR_BIT])
        |=> (cnt_q == '0 && crc_q == INIT));

    assert_ctrl_noclear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_OFS && !wr_data[CLR_BIT])
        |=> ($stable(cnt_q) && $stable(crc_q)));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == DIN_OFS && cnt_q != CNT_TOP)
        |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_count_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == DIN_OFS && cnt_q == CNT_TOP) |=> (cnt_q == CNT_TOP));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($stable(cnt_q) && $stable(crc_q)));

    assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != CTRL_OFS && addr != DIN_OFS)
        |=> ($stable(cnt_q) && $stable(crc_q)));
endmodule

bind irda_crc16_engine irda_crc16_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CRC_W(CRC_W), .CNT_W(CNT_W),
    .CLR_BIT(CLR_BIT), .INIT(INIT), .CTRL_OFS(CTRL_OFS), .DIN_OFS(DIN_OFS),
    .CALC_OFS(CALC_OFS), .OUT_OFS(OUT_OFS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wr_data(wr_data),
    .crc_q  (crc_q),
    .cnt_q  (cnt_q)
);

// File: tb/irda_crc16_engine_test.sv
module irda_crc16_engine_test;
    localparam logic [7:0] A_CTRL = 8'h80; // R10 offsets
    localparam logic [7:0] A_DIN  = 8'h86;
    localparam logic [7:0] A_CALC = 8'h8A;
    localparam logic [7:0] A_OUT  = 8'h8E;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] m_crc;
    int          m_cnt;

    always #4 clk = ~clk;

    irda_crc16_engine uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) begin
            if (r[0]) r = (r >> 1) ^ 16'h8408;
            else      r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic feed(input logic [15:0] d);
        reg_write(A_DIN, d);
        m_crc = ref_step(m_crc, d[7:0]);
        if (m_cnt < 4095) m_cnt++;
    endtask

    task automatic do_clear();
        reg_write(A_CTRL, 16'h8000);
        m_crc = 16'hFFFF;
        m_cnt = 0;
    endtask

    task automatic check_all(input string req);
        logic [15:0] v;
        reg_read(A_CTRL, v); check(req, v, 16'(m_cnt));
        reg_read(A_CALC, v); check(req, v, m_crc);
        reg_read(A_OUT, v);  check(req, v, ~m_crc);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240517));
        m_crc = 16'hFFFF; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(A_CTRL, v); check("R1 count", v, 16'h0000);
        reg_read(A_CALC, v); check("R1 calc", v, 16'hFFFF);
        reg_read(A_OUT, v);  check("R1 out", v, 16'h0000);

        // R6 / R8 check vector
        do_clear();
        feed(16'h00CC); feed(16'h00F5); feed(16'h00F1); feed(16'h00A7);
        reg_read(A_CTRL, v); check("R6 count", v, 16'h0004);
        reg_read(A_OUT, v);  check("R6 out", v, 16'h51DF);
        reg_read(A_CALC, v); check("R8 calc raw", v, 16'hAE20);

        // R9 ignored writes and zero reads
        reg_write(A_CALC, 16'h1234);
        reg_write(A_OUT, 16'hFFFF);
        reg_write(8'h84, 16'h00AA);
        check_all("R9 ignored write");
        reg_read(A_DIN, v);  check("R9 input reads zero", v, 16'h0000);
        reg_read(8'h00, v);  check("R9 unmapped reads zero", v, 16'h0000);

        // R2 control write without clear bit
        reg_write(A_CTRL, 16'h7FFF);
        check_all("R2 no clear");
        do_clear();
        check_all("R2 clear");

        // R5 high bits ignored (also tag R4)
        feed(16'hAB12);
        feed(16'hF0FF);
        feed(16'h5A00);
        check_all("R5 high bits");

        // R3 back-to-back burst of 16 items
        @(negedge clk);
        wr_en = 1'b1; addr = A_DIN;
        for (int i = 0; i < 16; i++) begin
            logic [15:0] d;
            d = 16'($urandom);
            wr_data = d;
            m_crc = ref_step(m_crc, d[7:0]);
            m_cnt++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        check_all("R3 burst");

        // R4 random frames
        for (int f = 0; f < 8; f++) begin
            int len;
            do_clear();
            len = 1 + int'($urandom % 40);
            for (int i = 0; i < len; i++) feed(16'($urandom));
            check_all("R4 random frame");
        end

        // R7 saturation
        do_clear();
        @(negedge clk);
        wr_en = 1'b1; addr = A_DIN;
        for (int i = 0; i < 4100; i++) begin
            logic [15:0] d;
            d = 16'($urandom);
            wr_data = d;
            m_crc = ref_step(m_crc, d[7:0]);
            if (m_cnt < 4095) m_cnt++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        reg_read(A_CTRL, v); check("R7 saturated count", v, 16'h0FFF);
        check_all("R7 crc after saturation");
        do_clear();
        check_all("R2 clear after saturation");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule